// File: doc/BRIEF.md
# Spare Area Chunk Address Mapper

This block turns a request for a contiguous run of out-of-band (spare) bytes into a stream of single-byte accesses on a small buffer memory. The spare bytes of one flash page are not stored in one place. They are spread over eight physical spare buffers, one piece for each 512-byte sector of the page. Each buffer is 64 bytes long, and buffer n starts at byte address 0x1000 + n*64. The block takes the page size, the spare size, a logical start offset, a byte count and a direction. It walks the range one byte per cycle and pulses `done` when the range is covered.

The bytes a buffer holds are the spare size divided by the sector count, rounded down to an even number. The last buffer is open-ended: any logical offset at or past seven chunks maps into buffer 7, so the leftover bytes of an uneven split stay there. A write request takes its bytes from `inByte` and raises `inTake` in every cycle a byte is consumed. A read request returns each byte on `outByte`, with `outValid` high, one cycle after the memory read.

Top module: `spare_chunk_mapper`

## Requirements
- R1: The sector count is `pageBytes`/512, limited to the range 1 to 8. A 512-byte page therefore keeps all of its spare bytes in buffer 0.
- R2: The chunk size is `spareBytes` divided by the sector count, with bit 0 then cleared. For example 218 bytes over 8 sectors gives 26, and 54 over 4 gives 12.
- R3: The byte at logical offset o has the address 0x1000 + s*64 + (o - s*c), where c is the chunk size and s = min(o/c, 7). Every access falls in 0x1000..0x11FF.
- R4: An offset of 7*c or more stays in buffer 7 at position o - 7*c. The buffer index never goes past 7 and never wraps.
- R5: When a run reaches the end of a chunk in buffers 0..6, the next byte goes to position 0 of the next buffer. Otherwise consecutive accesses have consecutive addresses.
- R6: A request with length L > 0 makes exactly L accesses, in ascending logical order, on consecutive cycles. The first access comes s0+2 cycles after the edge that accepts `start`, where s0 is the buffer index of the start offset.
- R7: When `dirWrite`=1, each access raises `memWe` and `inTake`, with `memWdata` equal to `inByte` in the same cycle. `memRe` stays low.
- R8: When `dirWrite`=0, each access raises `memRe`. In the following cycle `outValid` is 1 and `outByte` equals `memRdata`. `memWe` stays low.
- R9: `done` is a one-cycle pulse, s0+L+2 cycles after the accepting edge when L > 0. No access occurs in the `done` cycle.
- R10: A request with L = 0 pulses `done` in the cycle right after the accepting edge and makes no access.
- R11: A `start` pulse that arrives while a request is in progress is ignored. So are changes to the request inputs during that time. The running request finishes with the parameters latched when it was accepted.
- R12: While reset is held, and after it, `memWe`, `memRe`, `inTake`, `outValid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| dirWrite | input | 1 | 1 = write buffers from inByte, 0 = read buffers to outByte |
| pageBytes | input | 14 | Page size in bytes |
| spareBytes | input | 8 | Spare size in bytes |
| reqOffset | input | 8 | Logical start offset in the spare area |
| reqLen | input | 9 | Number of bytes to move |
| inByte | input | 8 | Write data for the current byte |
| inTake | output | 1 | inByte is consumed this cycle |
| memAddr | output | 13 | Buffer memory byte address |
| memWe | output | 1 | Buffer memory write strobe |
| memRe | output | 1 | Buffer memory read strobe |
| memWdata | output | 8 | Buffer memory write data |
| memRdata | input | 8 | Buffer memory read data, one cycle after memRe |
| outValid | output | 1 | outByte carries a read byte |
| outByte | output | 8 | Read data stream |
| done | output | 1 | One-cycle pulse when the range is covered |

## Verification
The directed cases separate the geometries. A single-sector page keeps everything in buffer 0. An even split of 16 bytes exercises plain chunk crossings. The uneven 218-byte split shows the clamp to buffer 7, including starts that already lie past seven chunks. Non-listed sizes such as 54 and 30 bytes show the rounding down to an even chunk. Zero-length requests and a second `start` pulse with changed parameters in the middle of a run check that nothing happens when it should not. Random offsets, lengths and directions over the four supported geometries then compare every address, data byte and `done` cycle with a bench model.

// File: rtl/spare_map_pkg.sv
package spare_map_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;      // latch a new request
    logic locStep;   // move one buffer forward while locating the start
    logic xferStep;  // one byte moved
  } mapStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOCATE,
    ST_XFER,
    ST_FIN
  } mapState_t;

endpackage

// File: rtl/spare_map_dp.sv
module spare_map_dp
  import spare_map_pkg::*;
#(
  parameter int PAGE_W       = 14,
  parameter int SPARE_W      = 8,
  parameter int ADDR_W       = 13,
  parameter int NUM_BUFS     = 8,
  parameter int BUF_BYTES    = 64,
  parameter int SECTOR_BYTES = 512,
  parameter logic [ADDR_W-1:0] SPARE_BASE = 13'h1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  mapStrb_t           strb,
  input  logic [PAGE_W-1:0]  pageBytes,
  input  logic [SPARE_W-1:0] spareBytes,
  input  logic [SPARE_W-1:0] reqOffset,
  input  logic [SPARE_W:0]   reqLen,
  input  logic               memRe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               locDone,
  output logic               lastByte,
  output logic               zeroLen,
  output logic               rdValid
);

  localparam int SECT_SH  = $clog2(SECTOR_BYTES);
  localparam int IDX_W    = $clog2(NUM_BUFS);
  localparam int SH_W     = $clog2(IDX_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUFS - 1);

  logic [PAGE_W-1:0]  sectors;
  logic [SH_W-1:0]    shiftAmt;
  logic [SPARE_W-1:0] chunkCalc;

  logic [SPARE_W-1:0] chunkQ;
  logic [IDX_W-1:0]   idxQ;
  logic [SPARE_W-1:0] posQ;   // remainder while locating, then position in buffer
  logic [SPARE_W:0]   lenQ;
  logic               atChunkEnd;

  // Sector count and its log2, clamped to the number of buffers
  assign sectors = pageBytes >> SECT_SH;

  always_comb begin
    shiftAmt = '0;
    for (int i = 1; i <= IDX_W; i++) begin
      if (sectors >= PAGE_W'(1 << i)) shiftAmt = SH_W'(i);
    end
  end

  // Bytes per buffer, rounded down to even
  assign chunkCalc = (spareBytes >> shiftAmt) & ~SPARE_W'(1);

  assign zeroLen    = (reqLen == '0);
  assign locDone    = (idxQ == LAST_IDX) || (posQ < chunkQ);
  assign lastByte   = (lenQ == (SPARE_W+1)'(1));
  assign atChunkEnd = (idxQ != LAST_IDX) && (posQ == chunkQ - SPARE_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chunkQ <= '0;
      idxQ   <= '0;
      posQ   <= '0;
      lenQ   <= '0;
    end else if (strb.load) begin
      chunkQ <= chunkCalc;
      idxQ   <= '0;
      posQ   <= reqOffset;
      lenQ   <= reqLen;
    end else if (strb.locStep) begin
      posQ <= posQ - chunkQ;
      idxQ <= idxQ + IDX_W'(1);
    end else if (strb.xferStep) begin
      lenQ <= lenQ - (SPARE_W+1)'(1);
      if (atChunkEnd) begin
        idxQ <= idxQ + IDX_W'(1);
        posQ <= '0;
      end else begin
        posQ <= posQ + SPARE_W'(1);
      end
    end
  end

  // Read data comes back one cycle after the strobe
  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= memRe;
  end

  assign memAddr = SPARE_BASE
                 + ADDR_W'(idxQ) * ADDR_W'(BUF_BYTES)
                 + ADDR_W'(posQ);

endmodule

// File: rtl/spare_map_ctrl.sv
module spare_map_ctrl
  import spare_map_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     dirWrite,
  input  logic     zeroLen,
  input  logic     locDone,
  input  logic     lastByte,
  output mapStrb_t strb,
  output logic     memWe,
  output logic     memRe,
  output logic     done
);

  mapState_t stateQ, stateD;
  logic      dirQ;

  always_comb begin
    strb          = '0;
    strb.load     = (stateQ == ST_IDLE) && start;
    strb.locStep  = (stateQ == ST_LOCATE) && !locDone;
    strb.xferStep = (stateQ == ST_XFER);
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (start) stateD = zeroLen ? ST_FIN : ST_LOCATE;
      ST_LOCATE: if (locDone) stateD = ST_XFER;
      ST_XFER:   if (lastByte) stateD = ST_FIN;
      ST_FIN:    stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      dirQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strb.load) dirQ <= dirWrite;
    end
  end

  assign memWe = (stateQ == ST_XFER) && dirQ;
  assign memRe = (stateQ == ST_XFER) && !dirQ;
  assign done  = (stateQ == ST_FIN);

endmodule

// File: rtl/spare_chunk_mapper.sv
module spare_chunk_mapper
  import spare_map_pkg::*;
#(
  parameter int PAGE_W       = 14,
  parameter int SPARE_W      = 8,
  parameter int ADDR_W       = 13,
  parameter int NUM_BUFS     = 8,
  parameter int BUF_BYTES    = 64,
  parameter int SECTOR_BYTES = 512,
  parameter logic [ADDR_W-1:0] SPARE_BASE = 13'h1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               dirWrite,
  input  logic [PAGE_W-1:0]  pageBytes,
  input  logic [SPARE_W-1:0] spareBytes,
  input  logic [SPARE_W-1:0] reqOffset,
  input  logic [SPARE_W:0]   reqLen,
  input  logic [7:0]         inByte,
  output logic               inTake,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memWe,
  output logic               memRe,
  output logic [7:0]         memWdata,
  input  logic [7:0]         memRdata,
  output logic               outValid,
  output logic [7:0]         outByte,
  output logic               done
);

  mapStrb_t strb;
  logic     locDone, lastByte, zeroLen, rdValid;

  spare_map_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .dirWrite (dirWrite),
    .zeroLen  (zeroLen),
    .locDone  (locDone),
    .lastByte (lastByte),
    .strb     (strb),
    .memWe    (memWe),
    .memRe    (memRe),
    .done     (done)
  );

  spare_map_dp #(
    .PAGE_W       (PAGE_W),
    .SPARE_W      (SPARE_W),
    .ADDR_W       (ADDR_W),
    .NUM_BUFS     (NUM_BUFS),
    .BUF_BYTES    (BUF_BYTES),
    .SECTOR_BYTES (SECTOR_BYTES),
    .SPARE_BASE   (SPARE_BASE)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pageBytes  (pageBytes),
    .spareBytes (spareBytes),
    .reqOffset  (reqOffset),
    .reqLen     (reqLen),
    .memRe      (memRe),
    .memAddr    (memAddr),
    .locDone    (locDone),
    .lastByte   (lastByte),
    .zeroLen    (zeroLen),
    .rdValid    (rdValid)
  );

  assign inTake   = memWe;
  assign memWdata = inByte;
  assign outValid = rdValid;
  assign outByte  = memRdata;

endmodule

// File: rtl/spare_map_checker.sv
module spare_map_checker #(
  parameter int SPARE_W   = 8,
  parameter int ADDR_W    = 13,
  parameter int NUM_BUFS  = 8,
  parameter int BUF_BYTES = 64,
  parameter logic [ADDR_W-1:0] SPARE_BASE = 13'h1000
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [SPARE_W:0]  reqLen,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWe,
  input logic              memRe,
  input logic              outValid,
  input logic              done
);

  localparam int OFF_B = $clog2(BUF_BYTES);
  localparam logic [ADDR_W-1:0] TOP_ADDR = SPARE_BASE + ADDR_W'(NUM_BUFS * BUF_BYTES);

  logic acc;
  logic busyM;
  assign acc = memWe || memRe;

  // Independent view of whether a request is running
  always_ff @(posedge clk) begin
    if (!rstN)                busyM <= 1'b0;
    else if (!busyM && start) busyM <= 1'b1;
    else if (done)            busyM <= 1'b0;
  end

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  assert_bounds_R3: assert property (@(posedge clk) disable iff (!rstN)
    acc |-> (memAddr >= SPARE_BASE && memAddr < TOP_ADDR));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (acc && $past(acc)) |->
      (memAddr == $past(memAddr) + ADDR_W'(1)) ||
      ((memAddr[OFF_B-1:0] == '0) &&
       (memAddr[ADDR_W-1:OFF_B] == $past(memAddr[ADDR_W-1:OFF_B]) + (ADDR_W-OFF_B)'(1))));

  assert_read_ret_R8: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> outValid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !acc);

  assert_zero_len_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busyM && start && reqLen == '0) |=> done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busyM |-> !acc);

endmodule

bind spare_chunk_mapper spare_map_checker #(
  .SPARE_W    (SPARE_W),
  .ADDR_W     (ADDR_W),
  .NUM_BUFS   (NUM_BUFS),
  .BUF_BYTES  (BUF_BYTES),
  .SPARE_BASE (SPARE_BASE)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .reqLen   (reqLen),
  .memAddr  (memAddr),
  .memWe    (memWe),
  .memRe    (memRe),
  .outValid (outValid),
  .done     (done)
);

// File: tb/test_spare_chunk_mapper.sv
module test_spare_chunk_mapper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        dirWrite = 1'b0;
  logic [13:0] pageBytes = '0;
  logic [7:0]  spareBytes = '0;
  logic [7:0]  reqOffset = '0;
  logic [8:0]  reqLen = '0;
  logic [7:0]  inByte = '0;
  logic        inTake;
  logic [12:0] memAddr;
  logic        memWe, memRe;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = '0;
  logic        outValid;
  logic [7:0]  outByte;
  logic        done;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mem [0:511];
  int         expAddr [0:255];
  logic [7:0] srcBuf  [0:256];
  logic [7:0] expData [0:255];

  always #2 clk = ~clk;

  spare_chunk_mapper i_spare_chunk_mapper (
    .clk(clk), .rstN(rstN), .start(start), .dirWrite(dirWrite),
    .pageBytes(pageBytes), .spareBytes(spareBytes), .reqOffset(reqOffset),
    .reqLen(reqLen), .inByte(inByte), .inTake(inTake), .memAddr(memAddr),
    .memWe(memWe), .memRe(memRe), .memWdata(memWdata), .memRdata(memRdata),
    .outValid(outValid), .outByte(outByte), .done(done)
  );

  // Buffer memory model
  always @(posedge clk) if (memRe) memRdata <= mem[memAddr[8:0]];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int chunkOf(input int pb, input int sp);
    int n = pb / 512;
    if (n < 1) n = 1;
    if (n > 8) n = 8;
    return (sp / n) & ~1;
  endfunction

  function automatic int bufOf(input int off, input int cs);
    int s = off / cs;
    return (s > 7) ? 7 : s;
  endfunction

  task automatic runReq(input int pb, input int sp, input int off, input int len,
                        input bit wr, input bit poke, input string tag);
    int cs = chunkOf(pb, sp);
    int s0 = bufOf(off, cs);
    int expDone = (len == 0) ? 1 : s0 + len + 2;
    int a = 0, r = 0, firstN = -1, doneN = -1;
    int addrBad = 0, dataBad = 0, badAct = 0, badExp = 0, strayWr = 0;
    for (int j = 0; j < len; j++) begin
      int s = bufOf(off + j, cs);
      expAddr[j] = 'h1000 + s * 64 + (off + j - s * cs);
      srcBuf[j]  = 8'($urandom);
      expData[j] = mem[expAddr[j] - 'h1000];
    end
    srcBuf[len] = 8'($urandom);
    @(negedge clk);
    pageBytes = 14'(pb); spareBytes = 8'(sp); reqOffset = 8'(off);
    reqLen = 9'(len); dirWrite = wr; inByte = srcBuf[0]; start = 1'b1;
    for (int n = 1; n < 700; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && n == 3 && expDone > 5) begin
        start = 1'b1; reqOffset = 8'(~off); reqLen = 9'd0;
        pageBytes = 14'd512; spareBytes = 8'd2; dirWrite = ~wr;
      end
      if (memWe || memRe) begin
        if (firstN < 0) firstN = n;
        if (a >= len) strayWr++;
        else if (int'(memAddr) != expAddr[a]) begin
          if (addrBad == 0) begin badAct = int'(memAddr); badExp = expAddr[a]; end
          addrBad++;
        end
        if (memWe != wr || (memWe && !inTake)) strayWr++;
        if (memWe && a < len) begin
          if (memWdata != srcBuf[a]) dataBad++;
          mem[memAddr[8:0]] = memWdata;
        end
        a++;
        inByte = srcBuf[(a > len) ? len : a];
      end
      if (outValid) begin
        if (r >= len || outByte != expData[r]) dataBad++;
        r++;
      end
      if (done) begin doneN = n; break; end
    end
    start = 1'b0;
    chk(a == len, {tag, " R6 access count"}, a, len);
    chk(addrBad == 0, {tag, " R3 R4 R5 address"}, badAct, badExp);
    chk(strayWr == 0, {tag, wr ? " R7 strobe" : " R8 strobe"}, strayWr, 0);
    chk(dataBad == 0, {tag, wr ? " R7 write data" : " R8 read data"}, dataBad, 0);
    if (!wr) chk(r == len, {tag, " R8 returned bytes"}, r, len);
    if (len > 0) chk(firstN == s0 + 2, {tag, " R6 first access cycle"}, firstN, s0 + 2);
    chk(doneN == expDone, {tag, (len == 0) ? " R10 done cycle" : " R9 done cycle"}, doneN, expDone);
    @(negedge clk);
    chk(!done && !memWe && !memRe, {tag, " R9 done pulse"}, int'(done), 0);
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int pbT [4] = '{512, 2048, 4096, 4096};
    int spT [4] = '{16, 64, 128, 218};
    void'($urandom(32'h5EED_C0DE));
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    repeat (4) @(negedge clk);
    chk(!memWe && !memRe && !inTake && !outValid && !done, "R12 reset outputs", 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!memWe && !memRe && !outValid && !done, "R12 idle after reset", 0, 0);

    runReq(512, 16, 0, 16, 1'b1, 1'b0, "R1 single sector write");
    runReq(512, 16, 3, 9, 1'b0, 1'b0, "R1 single sector read");
    runReq(2048, 64, 10, 30, 1'b1, 1'b0, "R5 crossing write");
    runReq(2048, 64, 10, 30, 1'b0, 1'b0, "R5 crossing read");
    runReq(4096, 218, 170, 48, 1'b0, 1'b0, "R4 uneven tail read");
    runReq(4096, 218, 200, 18, 1'b1, 1'b0, "R4 start past seven chunks");
    runReq(4096, 218, 217, 1, 1'b0, 1'b0, "R4 last byte");
    runReq(4096, 128, 0, 128, 1'b0, 1'b0, "R3 full spare read");
    runReq(2048, 54, 0, 54, 1'b1, 1'b0, "R2 odd quotient");
    runReq(1024, 30, 5, 25, 1'b0, 1'b0, "R2 two sectors");
    runReq(4096, 218, 40, 0, 1'b1, 1'b0, "R10 zero length");
    runReq(4096, 218, 60, 100, 1'b1, 1'b1, "R11 start while busy");
    runReq(2048, 64, 0, 40, 1'b0, 1'b1, "R11 start while busy read");

    for (int k = 0; k < 40; k++) begin
      int m   = $urandom_range(3, 0);
      int off = $urandom_range(spT[m] - 1, 0);
      int len = $urandom_range(spT[m] - off, 0);
      runReq(pbT[m], spT[m], off, len, 1'($urandom), 1'($urandom), "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule